// File: doc/BRIEF.md
# Snoop Invalidate Queue with Acquire Barrier

This block sits beside a core's private cache and takes in coherence snoops that remove a line: plain invalidates and read-with-invalidate requests. Each snoop is acknowledged in the cycle it is written into a small first-in first-out queue. A read-with-invalidate also releases the line data in that cycle. The actual state change is written to the line-state array later. Until that write happens, local loads may still hit the old copy of the line.

Two protections keep the core consistent. First, any outgoing coherence message about a line is held back while that line still has an unapplied entry in the queue. Second, an acquire barrier keeps the core waiting until the queue is empty and every load issued before the barrier has returned. Loads made after the barrier then see the invalidated lines as misses and fetch fresh copies over the bus.

Top module: `snoop_inval_queue`

## Requirements
- R1: After reset the queue is empty: `invValid`, `snpAck`, `snpDataGo` and `barDone` are 0, and a message request for any address is granted.
- R2: While the queue holds fewer than DEPTH entries, `snpAck` equals `snpValid` in the same cycle, and the snoop is recorded at that clock edge. `snpAck` is never 1 without `snpValid`.
- R3: `snpDataGo` is 1 in the same cycle as `snpAck` when `snpRdx` is 1 (read-with-invalidate). It stays 0 for a plain invalidate (`snpRdx` = 0).
- R4: Queued invalidates appear on `invValid`/`invAddr` in arrival order. The head is consumed at each clock edge where `invValid` is 1 and `invBusy` is 0, so at most one is applied per cycle.
- R5: While `invBusy` is 1, `invValid` stays 1 and `invAddr` holds its value.
- R6: With DEPTH entries queued, `snpAck` is 0 even when `snpValid` is 1. It returns to 1 in the cycle after a slot is freed, and the stalled snoop then takes its place at the tail.
- R7: `msgGrant` is 0 when `msgReqValid` is 1 and `msgReqAddr` matches any unapplied queued entry. It is 1 for a request with no match, including in the cycle after the last matching entry is consumed.
- R8: After `barReq` is seen at a clock edge, `barDone` is 1 only while the queue is empty and no load is outstanding. With both already true, it is 1 in the cycle after that edge. The requester holds `barReq` until `barDone` and then drops it.
- R9: A load counts as outstanding from a cycle with `loadIssue` = 1 until a cycle with `loadDone` = 1. An outstanding load keeps `barDone` at 0 even when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snpValid | input | 1 | Snoop that removes a line is presented |
| snpRdx | input | 1 | 1: read-with-invalidate, 0: plain invalidate |
| snpAddr | input | AW | Line address of the snoop |
| snpAck | output | 1 | Snoop recorded and acknowledged this cycle |
| snpDataGo | output | 1 | Release line data for a read-with-invalidate |
| invValid | output | 1 | Head invalidate offered to the line-state array |
| invAddr | output | AW | Line address of the head invalidate |
| invBusy | input | 1 | Line-state array port is busy this cycle |
| msgReqValid | input | 1 | Core wants to send a coherence message |
| msgReqAddr | input | AW | Line address of that message |
| msgGrant | output | 1 | Message may be sent this cycle |
| loadIssue | input | 1 | A local load is issued |
| loadDone | input | 1 | A local load has completed |
| barReq | input | 1 | Acquire barrier request, held until done |
| barDone | output | 1 | Barrier satisfied |

## Verification
The most likely fault is a corrupted pointer or valid bit. That fault appears at the ports as a wrong address or order on `invAddr`, or as a stuck `invValid`, within one or two cycles of the next drain. A lost valid bit appears at once as a wrong `msgGrant` for a queued address. A wrong full flag appears as an acknowledge that a full queue should refuse. A miscounted load counter or an early barrier exit appears as `barDone` rising while a load is still outstanding or an entry is still queued, in the cycle where the fault occurs.

// File: rtl/sniq_pkg.sv
package sniq_pkg;
  // strobes from control to the entry storage
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

  typedef enum logic {BAR_IDLE = 1'b0, BAR_WAIT = 1'b1} barState_e;
endpackage

// File: rtl/sniq_dpath.sv
module sniq_dpath
  import sniq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  qStrobe_t      strobe,
  input  logic [AW-1:0] pushAddr,
  input  logic [AW-1:0] cmpAddr,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] headAddr,
  output logic          cmpHit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0]    slotAddr [DEPTH];
  logic [DEPTH-1:0] slotLive;
  logic [DEPTH-1:0] slotMatch;
  logic [PW-1:0]    wrPtr, rdPtr;

  assign full     = &slotLive;
  assign empty    = ~|slotLive;
  assign headAddr = slotAddr[rdPtr];
  assign cmpHit   = |(slotLive & slotMatch);

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    assign slotMatch[g] = (slotAddr[g] == cmpAddr);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotLive[g] <= 1'b0;
        slotAddr[g] <= '0;
      end else begin
        if (strobe.push && wrPtr == PW'(g)) begin
          slotLive[g] <= 1'b1;
          slotAddr[g] <= pushAddr;
        end else if (strobe.pop && rdPtr == PW'(g)) begin
          slotLive[g] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  // R6: control must never write into a full queue
  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !full);
  // R4: only a present head may be consumed
  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !empty);
  // R5: head address only moves when the head is consumed
  a_r5_head_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !strobe.pop) |=> $stable(headAddr));
endmodule

// File: rtl/sniq_ctrl.sv
module sniq_ctrl
  import sniq_pkg::*;
#(
  parameter int MAX_LOADS = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     snpValid,
  input  logic     snpRdx,
  input  logic     full,
  input  logic     empty,
  input  logic     cmpHit,
  input  logic     invBusy,
  input  logic     msgReqValid,
  input  logic     loadIssue,
  input  logic     loadDone,
  input  logic     barReq,
  output qStrobe_t strobe,
  output logic     snpAck,
  output logic     snpDataGo,
  output logic     invValid,
  output logic     msgGrant,
  output logic     barDone
);
  localparam int LW = $clog2(MAX_LOADS + 1);

  logic [LW-1:0] loadCnt;
  barState_e     barState;

  assign snpAck      = snpValid && !full;
  assign snpDataGo   = snpAck && snpRdx;
  assign invValid    = !empty;
  assign strobe.push = snpAck;
  assign strobe.pop  = invValid && !invBusy;
  assign msgGrant    = msgReqValid && !cmpHit;
  assign barDone     = (barState == BAR_WAIT) && empty && (loadCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadCnt <= '0;
    end else if (loadIssue && !loadDone) begin
      loadCnt <= loadCnt + 1'b1;
    end else if (loadDone && !loadIssue) begin
      loadCnt <= loadCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      barState <= BAR_IDLE;
    end else begin
      case (barState)
        BAR_IDLE: if (barReq)  barState <= BAR_WAIT;
        BAR_WAIT: if (barDone) barState <= BAR_IDLE;
        default:               barState <= BAR_IDLE;
      endcase
    end
  end

  // R2: an acknowledge always answers a presented snoop
  a_r2_ack_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    snpAck |-> snpValid);
  // R3: data release only accompanies an accepted snoop
  a_r3_data_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    snpDataGo |-> (snpAck && snpRdx));
  // R9: a completion never arrives with no load outstanding
  a_r9_no_load_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && !loadIssue) |-> (loadCnt != '0));
  // R8: barrier done leaves no queued entry behind
  a_r8_done_drained: assert property (@(posedge clk) disable iff (!rstN)
    barDone |-> !strobe.pop);
endmodule

// File: rtl/snoop_inval_queue.sv
module snoop_inval_queue
  import sniq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DEPTH     = 4,
  parameter int MAX_LOADS = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          snpValid,
  input  logic          snpRdx,
  input  logic [AW-1:0] snpAddr,
  output logic          snpAck,
  output logic          snpDataGo,
  output logic          invValid,
  output logic [AW-1:0] invAddr,
  input  logic          invBusy,
  input  logic          msgReqValid,
  input  logic [AW-1:0] msgReqAddr,
  output logic          msgGrant,
  input  logic          loadIssue,
  input  logic          loadDone,
  input  logic          barReq,
  output logic          barDone
);
  qStrobe_t strobe;
  logic     qFull, qEmpty, qHit;

  sniq_ctrl #(.MAX_LOADS(MAX_LOADS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .snpValid(snpValid), .snpRdx(snpRdx),
    .full(qFull), .empty(qEmpty), .cmpHit(qHit),
    .invBusy(invBusy), .msgReqValid(msgReqValid),
    .loadIssue(loadIssue), .loadDone(loadDone), .barReq(barReq),
    .strobe(strobe), .snpAck(snpAck), .snpDataGo(snpDataGo),
    .invValid(invValid), .msgGrant(msgGrant), .barDone(barDone)
  );

  sniq_dpath #(.AW(AW), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pushAddr(snpAddr), .cmpAddr(msgReqAddr),
    .full(qFull), .empty(qEmpty), .headAddr(invAddr), .cmpHit(qHit)
  );

  // R7: the head entry's line can never be granted a message
  a_r7_head_blocks_msg: assert property (@(posedge clk) disable iff (!rstN)
    (msgReqValid && invValid && msgReqAddr == invAddr) |-> !msgGrant);
  // R5: a busy array port keeps the invalidate offered
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && invBusy) |=> invValid);
endmodule

// File: tb/snoop_inval_queue_bench.sv
module snoop_inval_queue_bench;
  localparam int AW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic snpValid = 1'b0, snpRdx = 1'b0;
  logic [AW-1:0] snpAddr = '0;
  logic snpAck, snpDataGo, invValid, msgGrant, barDone;
  logic [AW-1:0] invAddr;
  logic invBusy = 1'b1;
  logic msgReqValid = 1'b0;
  logic [AW-1:0] msgReqAddr = '0;
  logic loadIssue = 1'b0, loadDone = 1'b0, barReq = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  snoop_inval_queue #(.AW(AW), .DEPTH(DEPTH), .MAX_LOADS(8)) u_snoop_inval_queue (
    .clk(clk), .rstN(rstN),
    .snpValid(snpValid), .snpRdx(snpRdx), .snpAddr(snpAddr),
    .snpAck(snpAck), .snpDataGo(snpDataGo),
    .invValid(invValid), .invAddr(invAddr), .invBusy(invBusy),
    .msgReqValid(msgReqValid), .msgReqAddr(msgReqAddr), .msgGrant(msgGrant),
    .loadIssue(loadIssue), .loadDone(loadDone),
    .barReq(barReq), .barDone(barDone)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushOne(logic [AW-1:0] a, logic rdx);
    @(negedge clk);
    snpValid = 1'b1; snpAddr = a; snpRdx = rdx;
    #1;
    chk("R2 ack on snoop", snpAck, 1);
    chk("R3 data release", snpDataGo, rdx);
    @(posedge clk); #1;
    snpValid = 1'b0; snpRdx = 1'b0;
  endtask

  task automatic msgProbe(logic [AW-1:0] a, logic exp, string req);
    msgReqValid = 1'b1; msgReqAddr = a; #1;
    chk(req, msgGrant, exp);
    msgReqValid = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    chk("R1 invValid idle", invValid, 0);
    chk("R1 ack idle", snpAck, 0);
    chk("R1 data idle", snpDataGo, 0);
    chk("R1 barDone idle", barDone, 0);
    msgProbe(16'h0011, 1, "R1 grant when empty");
  endtask

  task automatic testOrder();
    pushOne(16'h0011, 1'b0);
    pushOne(16'h0022, 1'b1);
    @(negedge clk); #1;
    chk("R4 head valid", invValid, 1);
    chk("R4 head first", invAddr, 16'h0011);
    msgProbe(16'h0022, 0, "R7 block second entry");
    msgProbe(16'h0011, 0, "R7 block head entry");
    msgProbe(16'h0033, 1, "R7 grant unrelated");
    @(negedge clk); #1;
    chk("R5 held while busy", invAddr, 16'h0011);
    chk("R5 valid while busy", invValid, 1);
    invBusy = 1'b0;
    @(negedge clk); #1;
    chk("R4 second in order", invAddr, 16'h0022);
    msgProbe(16'h0011, 1, "R7 grant after drain");
    msgProbe(16'h0022, 0, "R7 still blocked");
    @(negedge clk); #1;
    chk("R4 drained one per cycle", invValid, 0);
    msgProbe(16'h0022, 1, "R7 grant after last drain");
    invBusy = 1'b1;
  endtask

  task automatic testFull();
    logic [AW-1:0] expSeq [DEPTH];
    for (int i = 0; i < DEPTH; i++) pushOne(16'h0040 + AW'(i), 1'b0);
    @(negedge clk);
    snpValid = 1'b1; snpAddr = 16'h0050; snpRdx = 1'b1; #1;
    chk("R6 stall when full", snpAck, 0);
    chk("R6 no data when stalled", snpDataGo, 0);
    @(negedge clk); #1;
    chk("R6 stall persists", snpAck, 0);
    invBusy = 1'b0;
    @(negedge clk);
    invBusy = 1'b1; #1;
    chk("R6 ack after slot frees", snpAck, 1);
    @(posedge clk); #1;
    snpValid = 1'b0; snpRdx = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) expSeq[i] = 16'h0041 + AW'(i);
    expSeq[DEPTH-1] = 16'h0050;
    @(negedge clk);
    invBusy = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      #1;
      chk("R4 drain order after stall", invAddr, expSeq[j]);
      @(negedge clk);
    end
    #1;
    chk("R4 empty after drain", invValid, 0);
    invBusy = 1'b1;
  endtask

  task automatic testBarrier();
    // barrier with nothing pending completes next cycle
    @(negedge clk);
    barReq = 1'b1;
    @(negedge clk); #1;
    chk("R8 immediate done", barDone, 1);
    barReq = 1'b0;
    @(negedge clk); #1;
    chk("R8 done clears", barDone, 0);
    // load outstanding plus a queued invalidate
    loadIssue = 1'b1;
    @(posedge clk); #1;
    loadIssue = 1'b0;
    pushOne(16'h0077, 1'b1);
    @(negedge clk);
    barReq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R8 wait for queued entry", barDone, 0);
    end
    invBusy = 1'b0;
    @(negedge clk); #1;
    chk("R8 queue drained", invValid, 0);
    chk("R9 wait for load", barDone, 0);
    loadDone = 1'b1; #1;
    chk("R9 not done before load retires", barDone, 0);
    @(negedge clk);
    loadDone = 1'b0; #1;
    chk("R8 done once drained", barDone, 1);
    barReq = 1'b0;
    @(negedge clk); #1;
    chk("R8 done returns low", barDone, 0);
    invBusy = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testOrder();
    testFull();
    testBarrier();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule